// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block is the per-warp control stack of a 32-lane SIMT core whose lanes share one program counter. For every control-flow request that the issue stage presents, it returns the program counter and the active-lane mask the warp should run next. It splits the warp on a divergent conditional branch and parks the lanes that are waiting. It later brings them back when the core executes a join at a reconvergence point.

An indirect branch gives each lane its own target. The block does not push one entry per distinct target. Instead, each execution of the branch serves one target group. That group is the lowest-numbered active lane and every active lane whose target equals its target. The lanes still waiting are pushed as one re-execute entry whose PC is the branch itself. A later join returns the warp to the branch with only those lanes active, and the branch then serves the next group. Each entry holds a lane mask, a PC and a 2-bit kind: reconverge, re-execute or deferred path. Spilling to local memory is not built. A push that does not fit is reported through a one-cycle overflow pulse, and the stack is left unchanged. A join on an empty stack is reported the same way through underflow.

Occupancy is tracked by a three-state machine:
- States: `ST_EMPTY`, `ST_PARTIAL`, `ST_FULL`.
- Transitions:
  - `ST_EMPTY`→`ST_PARTIAL` on a push.
  - `ST_PARTIAL`→`ST_PARTIAL` on a push or pop that leaves the stack neither empty nor full.
  - `ST_PARTIAL`→`ST_FULL` when a push reaches the depth.
  - `ST_FULL`→`ST_PARTIAL` on a pop.
  - `ST_PARTIAL`→`ST_EMPTY` on the last pop.
  - Any state stays where it is on an idle cycle or a rejected request.

Top module: `simt_recon_stack`

## Requirements
- R1: After reset, out_valid, next_pc, next_mask, overflow and underflow are all zero and the stack is empty.
- R2: A request is taken when op_valid is high. Its result appears with out_valid high on the next clock edge. op_code encodings are 00 setup, 01 conditional branch, 10 indirect branch and 11 join. In a cycle without a request, out_valid drops and next_pc and next_mask keep their values.
- R3: On a conditional branch, the taken lanes are taken_mask AND cur_mask. If no active lane is taken, the result is cur_pc+1 with cur_mask. If every active lane is taken, the result is br_target with cur_mask. In both cases nothing is pushed.
- R4: On a divergent conditional branch, two entries are pushed. First a reconverge entry (reconv_pc, cur_mask), then on top of it a deferred entry (cur_pc+1, the not-taken active lanes). The result is br_target with the taken lanes.
- R5: A setup request (op 00) pushes a reconverge entry (reconv_pc, cur_mask) and returns cur_pc+1 with cur_mask.
- R6: An indirect branch reads lane i's target from lane_targets bits [i*32 +: 32]. The group is every active lane whose target equals that of the lowest-numbered active lane, and the result is that target with the group mask. If active lanes remain outside the group, an entry (cur_pc, remaining lanes) is pushed. Otherwise nothing is pushed. With no active lane the result is cur_pc+1 with mask zero.
- R7: A join on a non-empty stack pops the top entry and returns its PC and mask, in last-in first-out order.
- R8: A join on an empty stack pulses underflow for the result cycle, returns cur_pc with cur_mask, and leaves the stack empty.
- R9: A push that needs more free entries than remain (one for setup or a splitting indirect branch, two for a divergent conditional) pulses overflow, returns cur_pc with cur_mask, and leaves the stack unchanged. The default depth is 16.
- R10: overflow and underflow are never high together, and are high only in a cycle where out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 2 | Request kind: 00 setup, 01 conditional, 10 indirect, 11 join |
| cur_pc | input | 32 | PC of the requesting instruction |
| cur_mask | input | 32 | Currently active lanes |
| taken_mask | input | 32 | Per-lane condition result for a conditional branch |
| br_target | input | 32 | Target of a conditional branch |
| reconv_pc | input | 32 | Reconvergence PC for setup or conditional branch |
| lane_targets | input | 1024 | Per-lane targets of an indirect branch, lane i at bits [i*32 +: 32] |
| out_valid | output | 1 | Result present |
| next_pc | output | 32 | PC the warp runs next |
| next_mask | output | 32 | Lane mask the warp runs next |
| overflow | output | 1 | Push rejected, no room |
| underflow | output | 1 | Join on empty stack |

## Verification
The conditional branch is tried with no active lane taken, with every active lane taken while inactive lanes carry stray taken bits, and with an interleaved split. These three cases separate the no-push paths from the two-entry push and show that inactive lanes are masked out. The indirect branch is driven with targets falling in three interleaved groups, walked to completion through joins. It is also driven with a mask whose lowest active lane is not lane 0, with a single shared target, and with no active lane. Together these show that group selection follows the lowest active lane and that a re-execute entry is pushed only while lanes remain. Filling the stack to one below the depth and then to the full depth separates the two-entry overflow limit from the one-entry limit. Draining it afterwards shows that rejected pushes left the contents intact.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

    typedef enum logic [1:0] {
        OP_SETUP    = 2'b00,
        OP_COND     = 2'b01,
        OP_INDIRECT = 2'b10,
        OP_JOIN     = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ENT_NONE   = 2'b00,
        ENT_RECONV = 2'b01,
        ENT_REEXEC = 2'b10,
        ENT_DEFER  = 2'b11
    } ent_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'b00,
        ST_PARTIAL = 2'b01,
        ST_FULL    = 2'b10
    } occ_e;

endpackage

// File: rtl/simt_stack_store.sv
module simt_stack_store
    import simt_stack_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_cnt,
    input  logic             pop,
    input  logic [LANES-1:0] a_mask,
    input  logic [PCW-1:0]   a_pc,
    input  ent_e             a_kind,
    input  logic [LANES-1:0] b_mask,
    input  logic [PCW-1:0]   b_pc,
    input  ent_e             b_kind,
    output logic [LANES-1:0] top_mask,
    output logic [PCW-1:0]   top_pc,
    output ent_e             top_kind,
    output logic [CW-1:0]    count
);

    logic [LANES-1:0] mem_mask [DEPTH];
    logic [PCW-1:0]   mem_pc   [DEPTH];
    ent_e             mem_kind [DEPTH];
    logic [DEPTH-1:0] wr_a;
    logic [DEPTH-1:0] wr_b;
    logic [CW-1:0]    top_idx;
    logic [CW-1:0]    above;

    assign above   = count + CW'(1);
    assign top_idx = count - CW'(1);

    // one write strobe pair per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [CW-1:0] SLOT = CW'(g);
        assign wr_a[g] = (push_cnt != 2'd0) && (count == SLOT);
        assign wr_b[g] = (push_cnt == 2'd2) && (above == SLOT);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_a[i]) begin
                mem_mask[i] <= a_mask;
                mem_pc[i]   <= a_pc;
                mem_kind[i] <= a_kind;
            end else if (wr_b[i]) begin
                mem_mask[i] <= b_mask;
                mem_pc[i]   <= b_pc;
                mem_kind[i] <= b_kind;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CW'(push_cnt) - CW'(pop);
        end
    end

    always_comb begin
        if (count == '0) begin
            top_mask = '0;
            top_pc   = '0;
            top_kind = ENT_NONE;
        end else begin
            top_mask = mem_mask[top_idx[IW-1:0]];
            top_pc   = mem_pc[top_idx[IW-1:0]];
            top_kind = mem_kind[top_idx[IW-1:0]];
        end
    end

endmodule

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] tk_lanes,
    output logic [LANES-1:0] nt_lanes,
    output logic             none_taken,
    output logic             all_taken
);

    assign tk_lanes   = taken_mask & cur_mask;
    assign nt_lanes   = cur_mask & ~taken_mask;
    assign none_taken = (tk_lanes == '0);
    assign all_taken  = (nt_lanes == '0);

endmodule

// File: rtl/simt_lane_group_pick.sv
module simt_lane_group_pick #(
    parameter int LANES = 32,
    parameter int PCW   = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0]     active,
    input  logic [LANES*PCW-1:0] targets,
    output logic                 lead_valid,
    output logic [PCW-1:0]       lead_tgt,
    output logic [LANES-1:0]     grp_mask,
    output logic [LANES-1:0]     rem_mask
);

    logic [LW-1:0]    lead_idx;
    logic [LANES-1:0] same_tgt;

    // lowest-numbered active lane wins: scan downward so the last hit is the lowest
    always_comb begin
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (active[i]) begin
                lead_idx = LW'(i);
            end
        end
    end

    assign lead_valid = (active != '0);
    assign lead_tgt   = targets[lead_idx*PCW +: PCW];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign same_tgt[g] = (targets[g*PCW +: PCW] == lead_tgt);
    end

    assign grp_mask = active & same_tgt;
    assign rem_mask = active & ~same_tgt;

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
    import simt_stack_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 32,
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [1:0]           op_code,
    input  logic [PCW-1:0]       cur_pc,
    input  logic [LANES-1:0]     cur_mask,
    input  logic [LANES-1:0]     taken_mask,
    input  logic [PCW-1:0]       br_target,
    input  logic [PCW-1:0]       reconv_pc,
    input  logic [LANES*PCW-1:0] lane_targets,
    output logic                 out_valid,
    output logic [PCW-1:0]       next_pc,
    output logic [LANES-1:0]     next_mask,
    output logic                 overflow,
    output logic                 underflow
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL     = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_ROOM_TWO = CW'(DEPTH - 2);

    occ_e             st_q, st_d;
    logic [CW-1:0]    count;
    logic [CW-1:0]    cnt_nx;
    logic [PCW-1:0]   fall_pc;

    logic [1:0]       push_cnt;
    logic             pop;
    logic [LANES-1:0] a_mask, b_mask;
    logic [PCW-1:0]   a_pc, b_pc;
    ent_e             a_kind, b_kind;
    logic [LANES-1:0] top_mask;
    logic [PCW-1:0]   top_pc;
    ent_e             top_kind;

    logic [LANES-1:0] tk_lanes, nt_lanes;
    logic             none_taken, all_taken;
    logic             lead_valid;
    logic [PCW-1:0]   lead_tgt;
    logic [LANES-1:0] grp_mask, rem_mask;

    logic [PCW-1:0]   res_pc;
    logic [LANES-1:0] res_mask;
    logic             res_ovf, res_unf;

    assign fall_pc = cur_pc + PCW'(1);

    simt_stack_store #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_cnt (push_cnt),
        .pop      (pop),
        .a_mask   (a_mask),
        .a_pc     (a_pc),
        .a_kind   (a_kind),
        .b_mask   (b_mask),
        .b_pc     (b_pc),
        .b_kind   (b_kind),
        .top_mask (top_mask),
        .top_pc   (top_pc),
        .top_kind (top_kind),
        .count    (count)
    );

    simt_branch_split #(.LANES(LANES)) i_split (
        .cur_mask   (cur_mask),
        .taken_mask (taken_mask),
        .tk_lanes   (tk_lanes),
        .nt_lanes   (nt_lanes),
        .none_taken (none_taken),
        .all_taken  (all_taken)
    );

    simt_lane_group_pick #(.LANES(LANES), .PCW(PCW)) i_pick (
        .active     (cur_mask),
        .targets    (lane_targets),
        .lead_valid (lead_valid),
        .lead_tgt   (lead_tgt),
        .grp_mask   (grp_mask),
        .rem_mask   (rem_mask)
    );

    // request decode: stack actions and the result of this request
    always_comb begin
        push_cnt = 2'd0;
        pop      = 1'b0;
        a_mask   = cur_mask;
        a_pc     = reconv_pc;
        a_kind   = ENT_RECONV;
        b_mask   = nt_lanes;
        b_pc     = fall_pc;
        b_kind   = ENT_DEFER;
        res_pc   = cur_pc;
        res_mask = cur_mask;
        res_ovf  = 1'b0;
        res_unf  = 1'b0;
        if (op_valid) begin
            unique case (op_e'(op_code))
                OP_SETUP: begin
                    if (st_q == ST_FULL) begin
                        res_ovf = 1'b1;
                    end else begin
                        push_cnt = 2'd1;
                        res_pc   = fall_pc;
                    end
                end
                OP_COND: begin
                    if (none_taken) begin
                        res_pc = fall_pc;
                    end else if (all_taken) begin
                        res_pc = br_target;
                    end else if (count > CNT_ROOM_TWO) begin
                        res_ovf = 1'b1;
                    end else begin
                        push_cnt = 2'd2;
                        res_pc   = br_target;
                        res_mask = tk_lanes;
                    end
                end
                OP_INDIRECT: begin
                    if (!lead_valid) begin
                        res_pc = fall_pc;
                    end else if (rem_mask == '0) begin
                        res_pc   = lead_tgt;
                        res_mask = grp_mask;
                    end else if (st_q == ST_FULL) begin
                        res_ovf = 1'b1;
                    end else begin
                        push_cnt = 2'd1;
                        a_mask   = rem_mask;
                        a_pc     = cur_pc;
                        a_kind   = ENT_REEXEC;
                        res_pc   = lead_tgt;
                        res_mask = grp_mask;
                    end
                end
                OP_JOIN: begin
                    if (st_q == ST_EMPTY) begin
                        res_unf = 1'b1;
                    end else begin
                        pop      = 1'b1;
                        res_pc   = top_pc;
                        res_mask = top_mask;
                    end
                end
            endcase
        end
    end

    // occupancy state machine
    always_comb begin
        cnt_nx = count + CW'(push_cnt) - CW'(pop);
        if (cnt_nx == '0) begin
            st_d = ST_EMPTY;
        end else if (cnt_nx == CNT_FULL) begin
            st_d = ST_FULL;
        end else begin
            st_d = ST_PARTIAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            next_mask <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            out_valid <= op_valid;
            overflow  <= res_ovf;
            underflow <= res_unf;
            if (op_valid) begin
                next_pc   <= res_pc;
                next_mask <= res_mask;
            end
        end
    end

endmodule

// File: rtl/simt_recon_stack_chk.sv
module simt_recon_stack_chk
    import simt_stack_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_code,
    input logic [PCW-1:0]   cur_pc,
    input logic [LANES-1:0] cur_mask,
    input logic             out_valid,
    input logic [PCW-1:0]   next_pc,
    input logic [LANES-1:0] next_mask,
    input logic             overflow,
    input logic             underflow,
    input ent_e             top_kind
);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!out_valid && $stable(next_pc) && $stable(next_mask))); // R2

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow)); // R10

    AST_FLAG_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || underflow) |-> out_valid); // R10

    AST_UNDERFLOW_ON_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(op_code) == OP_JOIN)); // R8

    AST_NO_OVERFLOW_ON_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(op_code) != OP_JOIN)); // R9

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || underflow) |-> (next_pc == $past(cur_pc) && next_mask == $past(cur_mask))); // R9

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_code) != OP_JOIN) |->
        ((next_mask & ~$past(cur_mask)) == '0)); // R6

    AST_LEAD_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !overflow && $past(op_code) == OP_INDIRECT && $past(cur_mask) != '0) |->
        ((next_mask & ($past(cur_mask) & (~$past(cur_mask) + 1'b1))) != '0)); // R6

    AST_SPLIT_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !overflow && $past(op_code) == OP_COND && next_mask != $past(cur_mask)) |->
        (top_kind == ENT_DEFER)); // R4

endmodule

bind simt_recon_stack simt_recon_stack_chk #(.LANES(LANES), .PCW(PCW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .cur_pc    (cur_pc),
    .cur_mask  (cur_mask),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .next_mask (next_mask),
    .overflow  (overflow),
    .underflow (underflow),
    .top_kind  (top_kind)
);

// File: tb/test_simt_recon_stack.sv
module test_simt_recon_stack;

    localparam int LANES = 32;
    localparam int PCW   = 32;
    localparam int DEPTH = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 op_valid = 1'b0;
    logic [1:0]           op_code = 2'b00;
    logic [PCW-1:0]       cur_pc = '0;
    logic [LANES-1:0]     cur_mask = '0;
    logic [LANES-1:0]     taken_mask = '0;
    logic [PCW-1:0]       br_target = '0;
    logic [PCW-1:0]       reconv_pc = '0;
    logic [LANES*PCW-1:0] lane_targets = '0;
    logic                 out_valid;
    logic [PCW-1:0]       next_pc;
    logic [LANES-1:0]     next_mask;
    logic                 overflow;
    logic                 underflow;

    simt_recon_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) i_simt_recon_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .cur_pc       (cur_pc),
        .cur_mask     (cur_mask),
        .taken_mask   (taken_mask),
        .br_target    (br_target),
        .reconv_pc    (reconv_pc),
        .lane_targets (lane_targets),
        .out_valid    (out_valid),
        .next_pc      (next_pc),
        .next_mask    (next_mask),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic             v;
        logic [PCW-1:0]   pc;
        logic [LANES-1:0] m;
        logic             o;
        logic             u;
        string            req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // reference stack built from the requirements
    logic [LANES-1:0]     ms_mask [DEPTH];
    logic [PCW-1:0]       ms_pc   [DEPTH];
    int                   mcnt = 0;
    logic [PCW-1:0]       lpc = '0;
    logic [LANES-1:0]     lmsk = '0;
    logic [LANES*PCW-1:0] tgt_next = '0;

    function automatic void mpush(input logic [LANES-1:0] m, input logic [PCW-1:0] pc);
        ms_mask[mcnt] = m;
        ms_pc[mcnt]   = pc;
        mcnt++;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [PCW-1:0] pc,
                          input logic [LANES-1:0] m, input logic [LANES-1:0] tk,
                          input logic [PCW-1:0] bt, input logic [PCW-1:0] rp,
                          input string req);
        exp_t             e;
        logic [LANES-1:0] t, n, g, r;
        logic [PCW-1:0]   lt, fall;
        int               lead;
        e.v = 1'b1; e.o = 1'b0; e.u = 1'b0; e.pc = pc; e.m = m; e.req = req;
        fall = pc + 1;
        case (op)
            2'b00: begin
                if (mcnt == DEPTH) e.o = 1'b1;
                else begin mpush(m, rp); e.pc = fall; end
            end
            2'b01: begin
                t = tk & m; n = m & ~tk;
                if (t == '0) e.pc = fall;
                else if (n == '0) e.pc = bt;
                else if (mcnt > DEPTH - 2) e.o = 1'b1;
                else begin mpush(m, rp); mpush(n, fall); e.pc = bt; e.m = t; end
            end
            2'b10: begin
                if (m == '0) e.pc = fall;
                else begin
                    lead = 0;
                    for (int i = 0; i < LANES; i++) if (m[i]) begin lead = i; break; end
                    lt = tgt_next[lead*PCW +: PCW];
                    g = '0;
                    for (int i = 0; i < LANES; i++)
                        g[i] = m[i] && (tgt_next[i*PCW +: PCW] == lt);
                    r = m & ~g;
                    if (r == '0) begin e.pc = lt; e.m = g; end
                    else if (mcnt == DEPTH) e.o = 1'b1;
                    else begin mpush(r, pc); e.pc = lt; e.m = g; end
                end
            end
            default: begin
                if (mcnt == 0) e.u = 1'b1;
                else begin mcnt--; e.pc = ms_pc[mcnt]; e.m = ms_mask[mcnt]; end
            end
        endcase
        lpc = e.pc; lmsk = e.m;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; cur_pc = pc; cur_mask = m;
        taken_mask = tk; br_target = bt; reconv_pc = rp; lane_targets = tgt_next;
        @(posedge clk);
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        exp_t e;
        e.v = 1'b0; e.pc = lpc; e.m = lmsk; e.o = 1'b0; e.u = 1'b0; e.req = req;
        @(negedge clk);
        op_valid = 1'b0;
        @(posedge clk);
        q.push_back(e);
    endtask

    task automatic join_op(input logic [PCW-1:0] pc, input logic [LANES-1:0] m, input string req);
        run_op(2'b11, pc, m, '0, '0, '0, req);
    endtask

    // monitor: compare one result per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v || next_pc !== e.pc || next_mask !== e.m ||
                overflow !== e.o || underflow !== e.u) begin
                errors++;
                $display("FAIL %s: got v=%0b pc=%h m=%h o=%0b u=%0b exp v=%0b pc=%h m=%h o=%0b u=%0b",
                         e.req, out_valid, next_pc, next_mask, overflow, underflow,
                         e.v, e.pc, e.m, e.o, e.u);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (out_valid !== 1'b0 || next_pc !== '0 || next_mask !== '0 ||
            overflow !== 1'b0 || underflow !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b pc=%h m=%h o=%0b u=%0b expected all zero",
                     out_valid, next_pc, next_mask, overflow, underflow);
        end

        idle("R2 idle after reset");
        // R3 uniform conditionals, nothing pushed
        run_op(2'b01, 32'h10, 32'hFFFF_FFFF, 32'h0, 32'h40, 32'h60, "R3 none taken");
        run_op(2'b01, 32'h11, 32'h0000_FFFF, 32'hFFFF_00FF | 32'h0000_FF00, 32'h40, 32'h60, "R3 all active taken");
        idle("R2 hold");
        join_op(32'h41, 32'h0000_FFFF, "R8 underflow after uniform");
        // R4 divergence then R7 joins
        run_op(2'b01, 32'h20, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h50, 32'h60, "R4 divergent split");
        join_op(32'h51, 32'h0F0F_0F0F, "R7 pop deferred path");
        join_op(32'h22, 32'hF0F0_F0F0, "R7 pop reconverge");
        join_op(32'h61, 32'hFFFF_FFFF, "R8 underflow after drain");
        // R5 setup then R6 indirect walk over three groups
        for (int i = 0; i < LANES; i++) tgt_next[i*PCW +: PCW] = 32'h200 + 32'((i % 3) * 16);
        run_op(2'b00, 32'h100, 32'hFFFF_FFFF, '0, '0, 32'h180, "R5 setup");
        run_op(2'b10, 32'h101, 32'hFFFF_FFFF, '0, '0, '0, "R6 indirect group 0");
        join_op(32'h201, 32'h4924_9249, "R7 return to branch");
        run_op(2'b10, 32'h101, 32'hB6DB_6DB6, '0, '0, '0, "R6 indirect group 1");
        join_op(32'h211, 32'h9249_2492, "R7 return to branch again");
        run_op(2'b10, 32'h101, 32'h2492_4924, '0, '0, '0, "R6 indirect last group");
        join_op(32'h221, 32'h2492_4924, "R7 reconverge after indirect");
        join_op(32'h181, 32'hFFFF_FFFF, "R8 empty after indirect");
        // R6 shared target with high lanes only, and empty mask
        for (int i = 16; i < LANES; i++) tgt_next[i*PCW +: PCW] = 32'h300;
        run_op(2'b10, 32'h140, 32'hFFFF_0000, '0, '0, '0, "R6 single group lead lane 16");
        join_op(32'h301, 32'hFFFF_0000, "R6 nothing pushed");
        run_op(2'b10, 32'h150, 32'h0000_0000, '0, '0, '0, "R6 no active lane");
        run_op(2'b10, 32'h160, 32'hFFF0_0F00, '0, '0, '0, "R6 lead lane 8");
        join_op(32'h161, 32'h0, "R7 pop remaining lanes");
        // R9 fill to DEPTH-1, reject double push, fill, reject single pushes
        for (int i = 0; i < DEPTH - 1; i++)
            run_op(2'b00, 32'h400 + 32'(i), 32'h1 << i | 32'h8000_0000, '0, '0, 32'h500 + 32'(i), "R5 fill");
        run_op(2'b01, 32'h600, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h700, 32'h800, "R9 split needs two");
        run_op(2'b00, 32'h610, 32'h7, '0, '0, 32'h5FF, "R5 last slot");
        run_op(2'b00, 32'h620, 32'h3, '0, '0, 32'h900, "R9 setup on full");
        run_op(2'b10, 32'h630, 32'hFFFF_FFFF, '0, '0, '0, "R9 indirect split on full");
        idle("R2 hold after overflow");
        for (int i = 0; i < DEPTH; i++) join_op(32'h640, 32'h1, "R9 R7 drain unchanged");
        join_op(32'h650, 32'h5, "R8 underflow after drain");

        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule